// File: doc/BRIEF.md
# Nibble-Serial Memory Bus Master

This block sits between a processor core and a narrow memory bus whose four data lines carry commands, addresses and data in turn. The core asks for one of two transactions: reload the program counter at memories on the bus and fetch from there, or set the data pointer and read from there. Each request gives a 20-bit address and the number of nibbles to read. The sequencer converts it into a fixed series of bus cycles. A single command cycle comes first, then the five address nibbles. The command then changes to the matching read without a further strobe. One dummy strobe cycle for memory pipelining follows, and after it the requested data nibbles arrive. These nibbles are packed into a result word for the core.

The core side is a plain request/acknowledge handshake. A request is taken only while the sequencer is idle. Acknowledge pulses once, after the last nibble has been captured. The bus may run at half the core rate. In that case the sequencer moves forward only on core cycles where the bus-enable input is high, and holds every bus output otherwise.

Top module: `nib_bus_master`

## Requirements
- R1: After reset the block is idle: `req_ready`=1, `ack`=0, `bus_cmd_stb`=0, `bus_nib_oe`=0, `bus_dummy`=0, `bus_cmd`=2'b00 and `rdata`=0.
- R2: A request (`req_valid`=1) is taken on a clock edge only while `req_ready`=1, and `req_ready` drops for the whole transaction. Request inputs that are held or changed while busy do not affect the running transaction's bus address, command or result.
- R3: Each transaction opens with exactly one bus cycle in which `bus_cmd_stb`=1. The command code is 2'b00 (load program counter) when `req_kind`=0 and 2'b01 (load data pointer) when `req_kind`=1.
- R4: The five bus cycles after the command cycle drive the address on `bus_nib_o` with `bus_nib_oe`=1, least significant nibble first. `bus_nib_oe` is high in no other cycle.
- R5: Once the address is sent, `bus_cmd` changes to the read code without a strobe: 2'b10 after a program-counter load, 2'b11 after a data-pointer load. The read code holds through the dummy and data cycles.
- R6: Exactly one dummy cycle (`bus_dummy`=1) lies between the last address nibble and the first data nibble.
- R7: `req_cnt` values 1..15 read that many data nibbles, and 0 reads 16. Data nibble k is stored at `rdata[4k+3:4k]`, and nibbles beyond the count read as zero.
- R8: `ack` is high for exactly one core cycle, the cycle after the edge that captures the final nibble. A transaction spans 7+N bus cycles, so a 5-nibble read takes 12.
- R9: With `bus_en` low, the sequencer does not advance and all bus outputs hold their values. At half rate the transaction still spans 7+N enabled cycles.
- R10: `rdata` holds its value after `ack` until the next request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Bus cycle enable; tie high for full-rate bus |
| req_valid | input | 1 | Core request |
| req_kind | input | 1 | 0 = program-counter load and fetch, 1 = data-pointer load and read |
| req_addr | input | 20 | Target address |
| req_cnt | input | 4 | Data nibbles to read (0 means 16) |
| req_ready | output | 1 | Sequencer idle; a request would be taken |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 64 | Assembled read data, nibble 0 at bit 0 |
| bus_cmd | output | 2 | Current bus command code |
| bus_cmd_stb | output | 1 | Command strobe (command cycle) |
| bus_nib_o | output | 4 | Nibble driven onto the bus |
| bus_nib_oe | output | 1 | Nibble output enable (address cycles) |
| bus_dummy | output | 1 | Dummy pipelining strobe |
| bus_nib_i | input | 4 | Nibble received from the bus |

## Verification
On every cycle the assertions check the local rules of the bus sequence. The strobe lasts a single cycle and carries a load code. The dummy cycle carries a read code. Strobe, output enable and dummy never overlap. Outputs freeze while `bus_en` is low, acknowledge is a lone pulse, and idle `rdata` is stable. Only the bench's scenarios can show the things that need a memory model on the far side. These are the address arriving least significant nibble first, the exact length of each phase, and the correct data packing for every count. Each scenario is swept over both kinds, all 16 counts, several addresses, both bus rates, and with request inputs changed while the block is busy.

// File: rtl/nbm_pkg.sv
package nbm_pkg;
    typedef enum logic [1:0] {
        CMD_LOAD_PC = 2'b00,
        CMD_LOAD_DP = 2'b01,
        CMD_READ_PC = 2'b10,
        CMD_READ_DP = 2'b11
    } nbm_cmd_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CMD,
        PH_ADDR,
        PH_DUMMY,
        PH_DATA
    } nbm_phase_e;
endpackage

// File: rtl/nbm_seq.sv
module nbm_seq
    import nbm_pkg::*;
#(
    parameter int ADDR_NIBS = 5,
    parameter int MAX_NIBS  = 16,
    localparam int CNT_W    = $clog2(MAX_NIBS),
    localparam int IX_W     = $clog2((MAX_NIBS > ADDR_NIBS) ? MAX_NIBS : ADDR_NIBS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_en,
    input  logic            req_valid,
    input  logic            req_kind,
    input  logic [CNT_W-1:0] req_cnt,
    output logic            accept,
    output logic            capture,
    output logic [IX_W-1:0] idx,
    output logic            ready,
    output logic            cmd_stb,
    output logic            addr_oe,
    output logic            dummy,
    output logic [1:0]      cmd,
    output logic            ack
);
    typedef struct packed {
        nbm_phase_e      ph;
        logic            kind;
        logic [IX_W-1:0] idx;
        logic [IX_W-1:0] last;
        logic            ack;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.ack = 1'b0;
        accept  = 1'b0;
        capture = 1'b0;
        unique case (s_q.ph)
            PH_IDLE: begin
                if (req_valid) begin
                    accept    = 1'b1;
                    s_d.ph    = PH_CMD;
                    s_d.kind  = req_kind;
                    s_d.idx   = '0;
                    s_d.last  = IX_W'(req_cnt - 1'b1);
                end
            end
            PH_CMD: begin
                if (bus_en) begin
                    s_d.ph  = PH_ADDR;
                    s_d.idx = '0;
                end
            end
            PH_ADDR: begin
                if (bus_en) begin
                    if (s_q.idx == IX_W'(ADDR_NIBS - 1)) begin
                        s_d.ph = PH_DUMMY;
                    end else begin
                        s_d.idx = s_q.idx + 1'b1;
                    end
                end
            end
            PH_DUMMY: begin
                if (bus_en) begin
                    s_d.ph  = PH_DATA;
                    s_d.idx = '0;
                end
            end
            PH_DATA: begin
                if (bus_en) begin
                    capture = 1'b1;
                    if (s_q.idx == s_q.last) begin
                        s_d.ph  = PH_IDLE;
                        s_d.ack = 1'b1;
                    end else begin
                        s_d.idx = s_q.idx + 1'b1;
                    end
                end
            end
            default: s_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{ph: PH_IDLE, kind: 1'b0, idx: '0, last: '0, ack: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign idx     = s_q.idx;
    assign ready   = (s_q.ph == PH_IDLE);
    assign cmd_stb = (s_q.ph == PH_CMD);
    assign addr_oe = (s_q.ph == PH_ADDR);
    assign dummy   = (s_q.ph == PH_DUMMY);
    assign ack     = s_q.ack;

    always_comb begin
        if (s_q.ph == PH_IDLE) begin
            cmd = CMD_LOAD_PC;
        end else if (s_q.ph == PH_DUMMY || s_q.ph == PH_DATA) begin
            cmd = {1'b1, s_q.kind};
        end else begin
            cmd = {1'b0, s_q.kind};
        end
    end
endmodule

// File: rtl/nbm_addr_ser.sv
module nbm_addr_ser #(
    parameter int NIB_W     = 4,
    parameter int ADDR_NIBS = 5,
    parameter int IX_W      = 4,
    localparam int ADDR_W   = NIB_W * ADDR_NIBS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              oe,
    input  logic [IX_W-1:0]   idx,
    output logic [NIB_W-1:0]  nib_out
);
    logic [ADDR_W-1:0] addr_d, addr_q;
    logic [NIB_W-1:0]  slice [ADDR_NIBS];

    for (genvar g = 0; g < ADDR_NIBS; g++) begin : g_slice
        assign slice[g] = addr_q[g*NIB_W +: NIB_W];
    end

    always_comb begin
        addr_d = load ? addr_in : addr_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) addr_q <= '0;
        else        addr_q <= addr_d;
    end

    always_comb begin
        nib_out = '0;
        if (oe) begin
            for (int i = 0; i < ADDR_NIBS; i++) begin
                if (idx == IX_W'(i)) nib_out = slice[i];
            end
        end
    end
endmodule

// File: rtl/nbm_collect.sv
module nbm_collect #(
    parameter int NIB_W    = 4,
    parameter int MAX_NIBS = 16,
    parameter int IX_W     = 4,
    localparam int DATA_W  = NIB_W * MAX_NIBS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              capture,
    input  logic [IX_W-1:0]   idx,
    input  logic [NIB_W-1:0]  nib_in,
    output logic [DATA_W-1:0] data
);
    logic [DATA_W-1:0] data_d, data_q;
    logic [MAX_NIBS-1:0] wr_en;

    for (genvar g = 0; g < MAX_NIBS; g++) begin : g_wr
        assign wr_en[g] = capture && (idx == IX_W'(g));
    end

    always_comb begin
        data_d = data_q;
        if (clear) begin
            data_d = '0;
        end else begin
            for (int i = 0; i < MAX_NIBS; i++) begin
                if (wr_en[i]) data_d[i*NIB_W +: NIB_W] = nib_in;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) data_q <= '0;
        else        data_q <= data_d;
    end

    assign data = data_q;
endmodule

// File: rtl/nib_bus_master.sv
module nib_bus_master #(
    parameter int NIB_W     = 4,
    parameter int ADDR_NIBS = 5,
    parameter int MAX_NIBS  = 16,
    localparam int ADDR_W   = NIB_W * ADDR_NIBS,
    localparam int DATA_W   = NIB_W * MAX_NIBS,
    localparam int CNT_W    = $clog2(MAX_NIBS),
    localparam int IX_W     = $clog2((MAX_NIBS > ADDR_NIBS) ? MAX_NIBS : ADDR_NIBS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              req_valid,
    input  logic              req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [CNT_W-1:0]  req_cnt,
    output logic              req_ready,
    output logic              ack,
    output logic [DATA_W-1:0] rdata,
    output logic [1:0]        bus_cmd,
    output logic              bus_cmd_stb,
    output logic [NIB_W-1:0]  bus_nib_o,
    output logic              bus_nib_oe,
    output logic              bus_dummy,
    input  logic [NIB_W-1:0]  bus_nib_i
);
    logic            accept;
    logic            capture;
    logic [IX_W-1:0] idx;

    nbm_seq #(
        .ADDR_NIBS(ADDR_NIBS),
        .MAX_NIBS (MAX_NIBS)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_en   (bus_en),
        .req_valid(req_valid),
        .req_kind (req_kind),
        .req_cnt  (req_cnt),
        .accept   (accept),
        .capture  (capture),
        .idx      (idx),
        .ready    (req_ready),
        .cmd_stb  (bus_cmd_stb),
        .addr_oe  (bus_nib_oe),
        .dummy    (bus_dummy),
        .cmd      (bus_cmd),
        .ack      (ack)
    );

    nbm_addr_ser #(
        .NIB_W    (NIB_W),
        .ADDR_NIBS(ADDR_NIBS),
        .IX_W     (IX_W)
    ) u_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (accept),
        .addr_in(req_addr),
        .oe     (bus_nib_oe),
        .idx    (idx),
        .nib_out(bus_nib_o)
    );

    nbm_collect #(
        .NIB_W   (NIB_W),
        .MAX_NIBS(MAX_NIBS),
        .IX_W    (IX_W)
    ) u_collect (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (accept),
        .capture(capture),
        .idx    (idx),
        .nib_in (bus_nib_i),
        .data   (rdata)
    );
endmodule

// File: rtl/nbm_checker.sv
module nbm_checker #(
    parameter int NIB_W    = 4,
    parameter int MAX_NIBS = 16
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      bus_en,
    input logic                      req_valid,
    input logic                      req_ready,
    input logic                      ack,
    input logic [NIB_W*MAX_NIBS-1:0] rdata,
    input logic [1:0]                bus_cmd,
    input logic                      bus_cmd_stb,
    input logic [NIB_W-1:0]          bus_nib_o,
    input logic                      bus_nib_oe,
    input logic                      bus_dummy
);
    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd_stb && bus_en) |=> !bus_cmd_stb); // R3
    AST_STB_LOAD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cmd_stb |-> !bus_cmd[1]); // R3
    AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bus_cmd_stb, bus_nib_oe, bus_dummy})); // R4
    AST_DUMMY_READ_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_dummy |-> bus_cmd[1]); // R5
    AST_DUMMY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_dummy && bus_en) |=> !bus_dummy); // R6
    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack); // R8
    AST_ACK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (req_ready && !bus_nib_oe && !bus_dummy && !bus_cmd_stb)); // R8
    AST_HOLD_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_en && !req_ready) |=> ($stable(bus_cmd) && $stable(bus_nib_o)
            && $stable(bus_dummy) && $stable(bus_nib_oe) && $stable(bus_cmd_stb))); // R9
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && !req_valid) |=> $stable(rdata)); // R10
endmodule

bind nib_bus_master nbm_checker #(
    .NIB_W   (NIB_W),
    .MAX_NIBS(MAX_NIBS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_en     (bus_en),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .ack        (ack),
    .rdata      (rdata),
    .bus_cmd    (bus_cmd),
    .bus_cmd_stb(bus_cmd_stb),
    .bus_nib_o  (bus_nib_o),
    .bus_nib_oe (bus_nib_oe),
    .bus_dummy  (bus_dummy)
);

// File: tb/nib_bus_master_bench.sv
module nib_bus_master_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b1;
    logic        half = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_kind = 1'b0;
    logic [19:0] req_addr = '0;
    logic [3:0]  req_cnt = '0;
    logic        req_ready, ack;
    logic [63:0] rdata;
    logic [1:0]  bus_cmd;
    logic        bus_cmd_stb, bus_nib_oe, bus_dummy;
    logic [3:0]  bus_nib_o, bus_nib_i;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // memory model state
    logic [1:0]  m_cmd = '0;
    logic [1:0]  m_rcmd = '0;
    logic [19:0] m_addr = '0;
    int          m_acnt = 0;
    int          m_didx = 0;
    int          m_len = 0;
    int          m_ndummy = 0;
    int          m_noe = 0;

    always #10 clk = ~clk;

    nib_bus_master u_nib_bus_master (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en),
        .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
        .req_cnt(req_cnt), .req_ready(req_ready), .ack(ack), .rdata(rdata),
        .bus_cmd(bus_cmd), .bus_cmd_stb(bus_cmd_stb), .bus_nib_o(bus_nib_o),
        .bus_nib_oe(bus_nib_oe), .bus_dummy(bus_dummy), .bus_nib_i(bus_nib_i)
    );

    function automatic logic [3:0] mem_nib(logic [19:0] a, int i);
        return 4'((a[3:0] ^ a[19:16]) + a[11:8] + i * 7);
    endfunction

    assign bus_nib_i = mem_nib(m_addr, m_didx);

    always @(negedge clk) begin
        bus_en <= half ? ~bus_en : 1'b1;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (rst_n && bus_en) begin
            if (bus_cmd_stb) begin
                m_cmd    <= bus_cmd;
                m_acnt   <= 0;
                m_addr   <= '0;
                m_len    <= 1;
                m_ndummy <= 0;
                m_noe    <= 0;
            end else if (!req_ready) begin
                m_len <= m_len + 1;
            end
            if (bus_nib_oe) begin
                m_addr[m_acnt*4 +: 4] <= bus_nib_o;
                m_acnt <= m_acnt + 1;
                m_noe  <= m_noe + 1;
            end
            if (bus_dummy) begin
                m_rcmd   <= bus_cmd;
                m_didx   <= 0;
                m_ndummy <= m_ndummy + 1;
            end else if (bus_cmd[1]) begin
                m_didx <= m_didx + 1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic xact(input logic kind, input logic [19:0] addr, input logic [3:0] cnt,
                        input bit spam);
        int n;
        int cyc;
        logic [63:0] exp;
        n = (cnt == 0) ? 16 : int'(cnt);
        exp = '0;
        for (int i = 0; i < n; i++) exp[i*4 +: 4] = mem_nib(addr, i);
        @(negedge clk);
        check(req_ready == 1'b1, "R2 ready before request", 64'(req_ready), 64'd1);
        req_valid = 1'b1; req_kind = kind; req_addr = addr; req_cnt = cnt;
        @(negedge clk);
        check(req_ready == 1'b0, "R2 busy after accept", 64'(req_ready), 64'd0);
        if (spam) begin
            req_kind = ~kind; req_addr = ~addr; req_cnt = cnt + 4'd3;
        end else begin
            req_valid = 1'b0;
        end
        cyc = 0;
        while (!ack && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
        req_valid = 1'b0;
        check(ack == 1'b1, "R8 ack seen", 64'(ack), 64'd1);
        check(rdata == exp, "R7 read data", rdata, exp);
        check(m_cmd == {1'b0, kind}, "R3 load code", 64'(m_cmd), 64'({1'b0, kind}));
        check(m_addr == addr, "R4 address LSB first", 64'(m_addr), 64'(addr));
        check(m_noe == 5, "R4 address cycles", 64'(m_noe), 64'd5);
        check(m_rcmd == {1'b1, kind}, "R5 read code", 64'(m_rcmd), 64'({1'b1, kind}));
        check(m_ndummy == 1, "R6 single dummy", 64'(m_ndummy), 64'd1);
        check(m_len == 7 + n, "R8 bus cycle span", 64'(m_len), 64'(7 + n));
        if (!half) begin
            check(cyc == 7 + n, "R8 core cycles at full rate", 64'(cyc), 64'(7 + n));
        end else begin
            check(cyc >= 2*(7+n) - 1 && cyc <= 2*(7+n), "R9 core cycles at half rate",
                  64'(cyc), 64'(2*(7+n)));
        end
        @(negedge clk);
        check(ack == 1'b0, "R8 ack single cycle", 64'(ack), 64'd0);
        check(req_ready == 1'b1, "R2 idle after ack", 64'(req_ready), 64'd1);
        @(negedge clk);
        @(negedge clk);
        check(rdata == exp, "R10 data held while idle", rdata, exp);
    endtask

    initial begin
        logic [19:0] addrs [3];
        addrs[0] = 20'h00000;
        addrs[1] = 20'hA5C3E;
        addrs[2] = 20'h1F2D7;
        #55;
        check(req_ready == 1'b1 && ack == 1'b0 && bus_cmd_stb == 1'b0 && bus_nib_oe == 1'b0
              && bus_dummy == 1'b0 && bus_cmd == 2'b00 && rdata == '0,
              "R1 reset state", rdata, 64'd0);
        rst_n = 1'b1;
        // R9: both bus rates
        for (int r = 0; r < 2; r++) begin
            half = (r == 1);
            for (int k = 0; k < 2; k++) begin
                for (int c = 0; c < 16; c++) begin
                    for (int a = 0; a < 3; a++) begin
                        // R2: request inputs toggled while busy on some runs
                        xact(k[0], addrs[a], 4'(c), (a == 1));
                    end
                end
            end
        end
        // R8: 5-nibble data-pointer read spans 12 bus cycles
        half = 1'b0;
        xact(1'b1, 20'h3C96B, 4'd5, 1'b0);
        check(m_len == 12, "R8 twelve-cycle read", 64'(m_len), 64'd12);
        summary();
    end

    initial begin
        wait (cycles > 150000);
        errors++;
        $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, 150000);
        summary();
    end
endmodule